// File: doc/BRIEF.md
# Stream Buffer with Data-Request Flag

This block holds the byte stream that arrives from a serial data receiver until a downstream consumer reads it. Bytes enter through a one-byte write port and leave in arrival order through a one-byte read port, one byte per clock in each direction. The two ports may be used in the same cycle.

A single data-request output tells the host when it may send more. The output is high only when three things hold at once. The power-up initialisation delay has elapsed. The command register port is not busy. The buffer has at least a fixed margin of free bytes. Because of that margin, a host that sees the flag high can send a burst of up to the margin's size without polling again.

The flag can fall at any moment, including partway through a byte, so the buffer never refuses a byte just because the flag is low. Only a full buffer drops a write, and a dropped write is recorded in a sticky overflow flag. The fill count and the full and empty flags are brought out for the consumer.

Top module: `stream_buf_req`

## Requirements
- R1: The buffer holds DEPTH = 2048 bytes. `full` is high exactly when `fill_count` equals 2048, and `empty` is high exactly when `fill_count` is 0.
- R2: A write (`wr_en` high) in a cycle where the buffer is not full stores `wr_data`. Bytes are read out in the order they were written.
- R3: A write in a cycle that begins with the buffer full is dropped, even if a read happens in the same cycle. From the next cycle `overflow` is high, and it stays high until reset.
- R4: A read (`rd_en` high) in a cycle that begins with the buffer empty is ignored. `rd_valid` is low in the next cycle, and `fill_count` is unchanged.
- R5: A read of a non-empty buffer presents the oldest byte on `rd_data`, with `rd_valid` high, in the cycle after `rd_en`.
- R6: `fill_count` changes by +1 for an accepted write alone, by -1 for an accepted read alone, and by 0 when both are accepted in the same cycle.
- R7: `data_req` is high exactly when initialisation has finished, `cmd_busy` is low, and the free space (2048 minus `fill_count`) is at least MARGIN = 32. At a fill of 2016 the flag is high; at 2017 it is low.
- R8: `data_req` is low in every cycle in which `cmd_busy` is high, with no cycle of delay. This covers single-cycle busy pulses.
- R9: Writes are accepted while `data_req` is low, provided the buffer is not full.
- R10: During reset and after it, the buffer is empty with `overflow` low. `data_req` stays low until INIT_CYCLES = 16 rising clock edges have passed since reset was released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe from the serial data receiver |
| wr_data | input | 8 | Byte to store |
| rd_en | input | 1 | Read strobe from the consumer |
| rd_data | output | 8 | Byte read, valid when rd_valid is high |
| rd_valid | output | 1 | rd_data holds a byte from the previous cycle's read |
| cmd_busy | input | 1 | Command register port is executing an operation |
| data_req | output | 1 | Host may send data or a command |
| fill_count | output | 12 | Number of bytes held |
| full | output | 1 | Buffer holds DEPTH bytes |
| empty | output | 1 | Buffer holds no bytes |
| overflow | output | 1 | Sticky: a write was dropped because the buffer was full |

## Verification
The assertions assume that all inputs are synchronous to `clk` and hold known values from the first edge after reset. They put no restriction on when the strobes or `cmd_busy` may be high: writes into a full buffer and reads from an empty one are legal, and the properties cover exactly those cases. The stimulus drives every input at the falling edge. It mixes random strobes and busy pulses with directed runs that fill the buffer to the request threshold, to capacity and beyond, and then drain it below empty, so every sequence it produces is one the assertions accept.

// File: rtl/sb_pkg.sv
package sb_pkg;

  // Fill level after one cycle with the given accepted strobes.
  function automatic int unsigned next_fill(int unsigned cur, logic push, logic pop);
    return cur + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction

  // Free space still meets the burst margin.
  function automatic logic has_room(int unsigned depth, int unsigned fill, int unsigned margin);
    return (fill <= depth) && ((depth - fill) >= margin);
  endfunction

  // Pointer advance for a buffer whose size is not a power of two.
  function automatic int unsigned bump_ptr(int unsigned p, int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/sb_mem.sv
module sb_mem #(
  parameter int DW    = 8,
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl #(
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic          wr_ok,
  output logic          rd_ok,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          overflow,
  output logic          rd_valid
);
  localparam bit IS_POW2 = (DEPTH & (DEPTH - 1)) == 0;

  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt_q;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign wr_ok = wr_en & ~full;
  assign rd_ok = rd_en & ~empty;
  assign waddr = wptr;
  assign raddr = rptr;
  assign count = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      overflow <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      cnt_q    <= CW'(sb_pkg::next_fill(32'(cnt_q), wr_ok, rd_ok));
      overflow <= overflow | (wr_en & full);
      rd_valid <= rd_ok;
    end
  end

  generate
    if (IS_POW2) begin : g_wrap_free
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          wptr <= '0;
          rptr <= '0;
        end else begin
          if (wr_ok) wptr <= wptr + 1'b1;
          if (rd_ok) rptr <= rptr + 1'b1;
        end
      end
    end else begin : g_wrap_cmp
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          wptr <= '0;
          rptr <= '0;
        end else begin
          if (wr_ok) wptr <= AW'(sb_pkg::bump_ptr(32'(wptr), DEPTH));
          if (rd_ok) rptr <= AW'(sb_pkg::bump_ptr(32'(rptr), DEPTH));
        end
      end
    end
  endgenerate
endmodule

// File: rtl/sb_req.sv
module sb_req #(
  parameter int DEPTH       = 2048,
  parameter int MARGIN      = 32,
  parameter int INIT_CYCLES = 16,
  parameter int CW          = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic          cmd_busy,
  output logic          init_done,
  output logic          room_ok,
  output logic          data_req
);
  localparam int IW = $clog2(INIT_CYCLES + 1);

  logic [IW-1:0] init_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                            init_cnt <= '0;
    else if (init_cnt != IW'(INIT_CYCLES)) init_cnt <= init_cnt + 1'b1;
  end

  assign init_done = (init_cnt == IW'(INIT_CYCLES));
  assign room_ok   = sb_pkg::has_room(DEPTH, 32'(count), MARGIN);
  // busy acts without delay so that even a one-cycle pulse is seen
  assign data_req  = init_done & room_ok & ~cmd_busy;
endmodule

// File: rtl/stream_buf_req.sv
module stream_buf_req #(
  parameter int DW          = 8,
  parameter int DEPTH       = 2048,
  parameter int MARGIN      = 32,
  parameter int INIT_CYCLES = 16,
  parameter int AW          = $clog2(DEPTH),
  parameter int CW          = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  input  logic          cmd_busy,
  output logic          data_req,
  output logic [CW-1:0] fill_count,
  output logic          full,
  output logic          empty,
  output logic          overflow
);
  logic          wr_ok, rd_ok, init_done, room_ok;
  logic [AW-1:0] waddr, raddr;

  sb_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .wr_ok(wr_ok), .rd_ok(rd_ok), .waddr(waddr), .raddr(raddr),
    .count(fill_count), .full(full), .empty(empty),
    .overflow(overflow), .rd_valid(rd_valid)
  );

  sb_mem #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk(clk), .we(wr_ok), .waddr(waddr), .wdata(wr_data),
    .re(rd_ok), .raddr(raddr), .rdata(rd_data)
  );

  sb_req #(.DEPTH(DEPTH), .MARGIN(MARGIN), .INIT_CYCLES(INIT_CYCLES), .CW(CW)) u_req (
    .clk(clk), .rst_n(rst_n), .count(fill_count), .cmd_busy(cmd_busy),
    .init_done(init_done), .room_ok(room_ok), .data_req(data_req)
  );
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int DEPTH  = 2048,
  parameter int MARGIN = 32,
  parameter int CW     = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic          cmd_busy,
  input logic          data_req,
  input logic [CW-1:0] fill_count,
  input logic          full,
  input logic          empty,
  input logic          overflow,
  input logic          rd_valid,
  input logic          wr_ok,
  input logic          rd_ok,
  input logic          init_done
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fill_count <= CW'(DEPTH));

  assert_ovf_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full) |=> overflow);

  assert_ovf_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && overflow) |=> overflow);

  assert_empty_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty) |=> !rd_valid);

  assert_fill_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (fill_count == $past(fill_count) + CW'($past(wr_ok)) - CW'($past(rd_ok))));

  assert_req_room_R7: assert property (@(posedge clk) disable iff (!rst_n)
    data_req |-> (fill_count <= CW'(DEPTH - MARGIN)));

  assert_req_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    data_req |-> !cmd_busy);

  assert_init_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !data_req);
endmodule

bind stream_buf_req sb_checker #(.DEPTH(DEPTH), .MARGIN(MARGIN), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .cmd_busy(cmd_busy),
  .data_req(data_req), .fill_count(fill_count), .full(full), .empty(empty),
  .overflow(overflow), .rd_valid(rd_valid), .wr_ok(wr_ok), .rd_ok(rd_ok),
  .init_done(init_done)
);

// File: tb/stream_buf_req_tb.sv
module stream_buf_req_tb;
  localparam int DEPTH  = 2048;
  localparam int MARGIN = 32;
  localparam int INIT   = 16;
  localparam int CW     = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n, wr_en, rd_en, cmd_busy;
  logic [7:0]    wr_data, rd_data;
  logic          rd_valid, data_req, full, empty, overflow;
  logic [CW-1:0] fill_count;

  int   n_chk = 0, n_err = 0, cyc = 0;
  bit   m_ovf = 0, done = 0;
  logic [7:0] q[$];

  always #10 clk = ~clk;

  stream_buf_req #(.DEPTH(DEPTH), .MARGIN(MARGIN), .INIT_CYCLES(INIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .rd_valid(rd_valid), .cmd_busy(cmd_busy), .data_req(data_req),
    .fill_count(fill_count), .full(full), .empty(empty), .overflow(overflow)
  );

  function automatic bit exp_req(int fill, bit busy, int c);
    return (c >= INIT) && !busy && (DEPTH - fill >= MARGIN);
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, compare at the next falling edge.
  task automatic step(bit w, logic [7:0] d, bit r, bit b);
    int   pre;
    bit   rok;
    logic [7:0] eb;
    wr_en = w; wr_data = d; rd_en = r; cmd_busy = b;
    @(posedge clk);
    pre = q.size();
    rok = r && pre > 0;
    eb  = 8'h00;
    if (rok) eb = q.pop_front();
    if (w && pre < DEPTH) q.push_back(d);
    if (w && pre == DEPTH) m_ovf = 1;
    cyc++;
    @(negedge clk);
    check("R6", int'(fill_count), q.size());
    check("R1", int'({full, empty}), int'({q.size() == DEPTH, q.size() == 0}));
    check("R3", int'(overflow), int'(m_ovf));
    check("R4", int'(rd_valid), int'(rok));
    if (rok) check("R2", int'(rd_data), int'(eb));
    check("R7", int'(data_req), int'(exp_req(q.size(), b, cyc)));
  endtask

  initial begin
    #3_000_000;
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int base;
    void'($urandom(32'h5EED));
    rst_n = 0; wr_en = 0; rd_en = 0; cmd_busy = 0; wr_data = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", int'(fill_count), 0);
    check("R10", int'(empty), 1);
    check("R10", int'(overflow), 0);
    check("R10", int'(data_req), 0);
    rst_n = 1;
    // R10: request stays low through initialisation even with writes arriving (R9)
    for (int i = 0; i < INIT - 1; i++) begin
      step(1, 8'(i), 0, 0);
      check("R10", int'(data_req), 0);
    end
    step(1, 8'hA5, 0, 0);
    check("R10", int'(data_req), 1);
    // R8: single-cycle busy pulse drops the flag at once
    step(0, 0, 0, 1);
    check("R8", int'(data_req), 0);
    step(0, 0, 0, 0);
    check("R8", int'(data_req), 1);
    // R9: writes accepted while busy holds the flag low
    base = int'(fill_count);
    for (int i = 0; i < 5; i++) step(1, 8'($urandom), 0, 1);
    check("R9", int'(fill_count), base + 5);
    // fill up to the threshold
    while (q.size() < DEPTH - MARGIN) step(1, 8'($urandom), 0, 0);
    check("R7", int'(data_req), 1);
    step(1, 8'h3C, 0, 0);
    check("R7", int'(data_req), 0);
    // fill to capacity, then overflow (also with a read in the same cycle)
    while (q.size() < DEPTH) step(1, 8'($urandom), 0, 0);
    check("R1", int'(full), 1);
    step(1, 8'hEE, 1, 0);
    check("R3", int'(overflow), 1);
    check("R3", int'(fill_count), DEPTH - 1);
    // R6: simultaneous read and write keep the count
    base = int'(fill_count);
    for (int i = 0; i < 8; i++) step(1, 8'($urandom), 1, 0);
    check("R6", int'(fill_count), base);
    // drain, then read while empty
    while (q.size() > 0) step(0, 0, 1, 0);
    step(0, 0, 1, 0);
    check("R4", int'(rd_valid), 0);
    check("R4", int'(fill_count), 0);
    check("R5", int'(empty), 1);
    check("R3", int'(overflow), 1);
    // random phase
    for (int i = 0; i < 6000; i++) begin
      int p;
      p = int'($urandom_range(0, 99));
      step(p < 55, 8'($urandom), p >= 35 && p < 90, $urandom_range(0, 9) == 0);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule